// File: doc/BRIEF.md
# Parallel Bus Read Initiator

This block is the requesting side of a parallel bus that carries address and data over one shared set of lines. A local client hands it a start address, a word count and a byte-lane mask. The block then runs one burst read. It first spends a single cycle putting the address and a read command on the bus. It then releases the shared address/data lines to the responding device. In every following cycle it offers a byte-enable pattern and signals that it is ready.

A word moves on each clock edge where both sides show ready. Each captured word goes into a one-entry holding stage and is handed out on a valid/ready stream. When that stream stalls, the block inserts wait states on the bus instead of dropping data. In the final data phase it withdraws the framing signal. After the last word it drives its ready line high for one cycle, releases everything, and stays idle for one cycle before it takes a new request.

Every shared active-low line is shown as an output-enable plus a value. An enable of 0 means high impedance.

Top module: `busReadInit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bus output enable (frame, address/data, command/byte-enable, initiator-ready) is 0, `rdValid` is 0 and `reqReady` is 1; an asserted reset in the middle of a burst releases the bus at once.
- R2: The cycle after a request is accepted is the single address phase: `adOe`=1 with `adOut` equal to the request address, `cbeOe`=1 with `cbeOut` equal to the read command (default 4'b0110), frame driven low and initiator-ready driven high.
- R3: In every data phase `adOe` is 0 and `cbeOut` carries the inverted byte-enable mask (bit n low means byte lane n is enabled).
- R4: A word is captured only on a rising edge where initiator-ready, target-ready and device-select are all low. Words appear on `rdData` in capture order, one cycle after capture, with `rdLast` set on the final word.
- R5: In a data phase, initiator-ready is high only while the holding stage is full and `rdReady` is low.
- R6: Frame is driven high exactly in the data phases whose completed-word count equals the burst length minus one. For a one-word read, frame is low only during the address phase.
- R7: In the cycle after the final capture, initiator-ready is driven high while frame, address/data and command/byte-enable are released. In the cycle after that, initiator-ready is released too.
- R8: One fully released idle cycle follows, with `reqReady` 0. After that, `reqReady` is 1, and it is never 1 while frame or initiator-ready is driven.
- R9: A requested length of 0 is run as a one-word burst.
- R10: While `rdValid` is 1 and `rdReady` is 0, `rdValid` stays 1 and `rdData` and `rdLast` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqAddr | input | ADW | Burst start address |
| reqLen | input | LW | Word count (0 runs as 1) |
| reqBe | input | ADW/8 | Byte-lane mask, 1 = lane enabled |
| frameOe | output | 1 | Frame line driven |
| frameVal | output | 1 | Frame line level (low = active) |
| adOe | output | 1 | Address/data lines driven |
| adOut | output | ADW | Address/data value driven |
| adIn | input | ADW | Address/data value sampled |
| cbeOe | output | 1 | Command/byte-enable lines driven |
| cbeOut | output | ADW/8 | Command or inverted byte enables |
| irdyOe | output | 1 | Initiator-ready line driven |
| irdyVal | output | 1 | Initiator-ready level (low = ready) |
| devselN | input | 1 | Device select from target, active low |
| trdyN | input | 1 | Target ready, active low |
| rdValid | output | 1 | Read word available |
| rdData | output | ADW | Read word |
| rdLast | output | 1 | Word is last of burst |
| rdReady | input | 1 | Client accepts the word |

## Verification
The checker watches several rules on every cycle. Address and command are only ever driven together with frame low, and for exactly one cycle. A wait state is tied to a stalled output stream. A three-way ready edge always loads the stream. The initiator-ready line is released right after its lone driven-high cycle. The stream holds steady under backpressure, and the request handshake is kept apart from a driven bus.

Only the bench scenarios can show end-to-end effects. These are the word ordering, the frame turning high in exactly the right data phase for each burst length, the inverted byte-enable values, the one-cycle idle gap, and recovery after a reset in the middle of a burst.

// File: rtl/busReadPkg.sv
`timescale 1ns/1ps
package busReadPkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_RECOV = 3'd3,
    ST_GAP   = 3'd4
  } busState_t;

  typedef struct packed {
    logic loadReq;
    logic driveAd;
    logic driveCbe;
    logic frameDrive;
    logic frameHigh;
    logic irdyDrive;
    logic irdyHigh;
    logic capture;
    logic lastBeat;
  } ctrlStrobe_t;

endpackage

// File: rtl/busReadCtrl.sv
`timescale 1ns/1ps
module busReadCtrl
  import busReadPkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [LW-1:0] reqLen,
  input  logic          trdyN,
  input  logic          devselN,
  input  logic          holdFree,
  output logic          reqReady,
  output ctrlStrobe_t   strobe
);

  localparam logic [LW-1:0] ONE = LW'(1);

  busState_t     state, stateNext;
  logic [LW-1:0] remaining;
  logic          finalPhase;

  assign finalPhase = (remaining == ONE);

  always_comb begin
    strobe    = '0;
    reqReady  = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        reqReady       = 1'b1;
        strobe.loadReq = reqValid;
        if (reqValid) stateNext = ST_ADDR;
      end
      ST_ADDR: begin
        strobe.driveAd    = 1'b1;
        strobe.driveCbe   = 1'b1;
        strobe.frameDrive = 1'b1;
        strobe.frameHigh  = 1'b0;
        strobe.irdyDrive  = 1'b1;
        strobe.irdyHigh   = 1'b1;
        stateNext         = ST_DATA;
      end
      ST_DATA: begin
        strobe.driveCbe   = 1'b1;
        strobe.frameDrive = 1'b1;
        strobe.frameHigh  = finalPhase;
        strobe.irdyDrive  = 1'b1;
        strobe.irdyHigh   = !holdFree;
        strobe.capture    = holdFree && !trdyN && !devselN;
        strobe.lastBeat   = finalPhase;
        if (strobe.capture && finalPhase) stateNext = ST_RECOV;
      end
      ST_RECOV: begin
        strobe.irdyDrive = 1'b1;
        strobe.irdyHigh  = 1'b1;
        stateNext        = ST_GAP;
      end
      ST_GAP: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
    end else begin
      state <= stateNext;
      if (strobe.loadReq) begin
        remaining <= (reqLen == '0) ? ONE : reqLen;
      end else if (strobe.capture) begin
        remaining <= remaining - ONE;
      end
    end
  end

endmodule

// File: rtl/busReadDp.sv
`timescale 1ns/1ps
module busReadDp
  import busReadPkg::*;
#(
  parameter int ADW = 32,
  parameter int BEW = ADW / 8,
  parameter logic [BEW-1:0] READ_CMD = BEW'(6)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [ADW-1:0]  reqAddr,
  input  logic [BEW-1:0]  reqBe,
  input  logic [ADW-1:0]  adIn,
  input  logic            rdReady,
  output logic            holdFree,
  output logic            frameOe,
  output logic            frameVal,
  output logic            adOe,
  output logic [ADW-1:0]  adOut,
  output logic            cbeOe,
  output logic [BEW-1:0]  cbeOut,
  output logic            irdyOe,
  output logic            irdyVal,
  output logic            rdValid,
  output logic [ADW-1:0]  rdData,
  output logic            rdLast
);

  logic [ADW-1:0] addrQ;
  logic [BEW-1:0] beQ;
  logic           holdValid;
  logic [ADW-1:0] holdData;
  logic           holdLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      beQ   <= '0;
    end else if (strobe.loadReq) begin
      addrQ <= reqAddr;
      beQ   <= reqBe;
    end
  end

  assign holdFree = !holdValid || rdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      holdLast  <= 1'b0;
    end else if (strobe.capture) begin
      holdValid <= 1'b1;
      holdData  <= adIn;
      holdLast  <= strobe.lastBeat;
    end else if (rdReady) begin
      holdValid <= 1'b0;
    end
  end

  assign frameOe  = strobe.frameDrive;
  assign frameVal = strobe.frameHigh;
  assign adOe     = strobe.driveAd;
  assign adOut    = addrQ;
  assign cbeOe    = strobe.driveCbe;
  assign cbeOut   = strobe.driveAd ? READ_CMD : ~beQ;
  assign irdyOe   = strobe.irdyDrive;
  assign irdyVal  = strobe.irdyHigh;

  assign rdValid = holdValid;
  assign rdData  = holdData;
  assign rdLast  = holdLast;

endmodule

// File: rtl/busReadInit.sv
`timescale 1ns/1ps
module busReadInit
  import busReadPkg::*;
#(
  parameter int ADW = 32,
  parameter int LW  = 4,
  parameter logic [ADW/8-1:0] READ_CMD = (ADW/8)'(6)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADW-1:0]     reqAddr,
  input  logic [LW-1:0]      reqLen,
  input  logic [ADW/8-1:0]   reqBe,
  output logic               frameOe,
  output logic               frameVal,
  output logic               adOe,
  output logic [ADW-1:0]     adOut,
  input  logic [ADW-1:0]     adIn,
  output logic               cbeOe,
  output logic [ADW/8-1:0]   cbeOut,
  output logic               irdyOe,
  output logic               irdyVal,
  input  logic               devselN,
  input  logic               trdyN,
  output logic               rdValid,
  output logic [ADW-1:0]     rdData,
  output logic               rdLast,
  input  logic               rdReady
);

  localparam int BEW = ADW / 8;

  ctrlStrobe_t strobe;
  logic        holdFree;

  busReadCtrl #(.LW(LW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqLen   (reqLen),
    .trdyN    (trdyN),
    .devselN  (devselN),
    .holdFree (holdFree),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  busReadDp #(.ADW(ADW), .BEW(BEW), .READ_CMD(READ_CMD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqBe    (reqBe),
    .adIn     (adIn),
    .rdReady  (rdReady),
    .holdFree (holdFree),
    .frameOe  (frameOe),
    .frameVal (frameVal),
    .adOe     (adOe),
    .adOut    (adOut),
    .cbeOe    (cbeOe),
    .cbeOut   (cbeOut),
    .irdyOe   (irdyOe),
    .irdyVal  (irdyVal),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .rdLast   (rdLast)
  );

endmodule

// File: rtl/busReadChk.sv
`timescale 1ns/1ps
module busReadChk #(
  parameter int ADW = 32,
  parameter logic [ADW/8-1:0] READ_CMD = (ADW/8)'(6)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             frameOe,
  input logic             frameVal,
  input logic             adOe,
  input logic             cbeOe,
  input logic [ADW/8-1:0] cbeOut,
  input logic             irdyOe,
  input logic             irdyVal,
  input logic             devselN,
  input logic             trdyN,
  input logic             rdValid,
  input logic [ADW-1:0]   rdData,
  input logic             rdLast,
  input logic             rdReady
);

  // R2
  addr_phase_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (cbeOe && cbeOut == READ_CMD && frameOe && !frameVal && irdyOe && irdyVal));

  // R3
  addr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |=> !adOe);

  // R4
  capture_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOe && !irdyVal && !trdyN && !devselN && !adOe) |=> rdValid);

  // R5
  wait_only_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOe && irdyVal && frameOe && !adOe) |-> (rdValid && !rdReady));

  // R6
  frame_high_with_irdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameOe && frameVal) |-> irdyOe);

  // R7
  irdy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOe && !frameOe) |=> !irdyOe);

  // R7
  irdy_high_before_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irdyOe && !frameOe) |-> irdyVal);

  // R8
  idle_handshake_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!frameOe && !irdyOe && !adOe && !cbeOe));

  // R10
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData) && $stable(rdLast)));

endmodule

bind busReadInit busReadChk #(.ADW(ADW), .READ_CMD(READ_CMD)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .frameOe  (frameOe),
  .frameVal (frameVal),
  .adOe     (adOe),
  .cbeOe    (cbeOe),
  .cbeOut   (cbeOut),
  .irdyOe   (irdyOe),
  .irdyVal  (irdyVal),
  .devselN  (devselN),
  .trdyN    (trdyN),
  .rdValid  (rdValid),
  .rdData   (rdData),
  .rdLast   (rdLast),
  .rdReady  (rdReady)
);

// File: tb/busReadInit_bench.sv
`timescale 1ns/1ps
module busReadInit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqLen = '0;
  logic [3:0]  reqBe = '0;
  logic        frameOe, frameVal, adOe, cbeOe, irdyOe, irdyVal;
  logic [31:0] adOut;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeOut;
  logic        devselN = 1'b1;
  logic        trdyN = 1'b1;
  logic        rdValid, rdLast;
  logic [31:0] rdData;
  logic        rdReady = 1'b1;

  int total = 0;
  int bad = 0;
  int cycleCnt = 0;

  always #4 clk = ~clk;

  busReadInit u_busReadInit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqBe(reqBe),
    .frameOe(frameOe), .frameVal(frameVal), .adOe(adOe), .adOut(adOut),
    .adIn(adIn), .cbeOe(cbeOe), .cbeOut(cbeOut), .irdyOe(irdyOe),
    .irdyVal(irdyVal), .devselN(devselN), .trdyN(trdyN),
    .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast), .rdReady(rdReady)
  );

  // vector: addr[71:40] len[39:36] be[35:32] trdyWaitPat[31:16] stallPat[15:0]
  localparam logic [71:0] VEC [5] = '{
    {32'h1000_0040, 4'd3,  4'hF, 16'h0005, 16'h0000},
    {32'h2000_0100, 4'd1,  4'h3, 16'h0000, 16'h0000},
    {32'h3000_0200, 4'd8,  4'hC, 16'h0000, 16'h0F0F},
    {32'h4000_0000, 4'd15, 4'h1, 16'h2492, 16'h5555},
    {32'hFFFF_FFFC, 4'd2,  4'hF, 16'h000F, 16'h00FF}
  };

  function automatic logic [31:0] wordOf(input logic [31:0] a, input int k);
    return a + 32'h0101_0101 * (k + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic checkReleased(input string req);
    check(!frameOe && !adOe && !cbeOe && !irdyOe, req, "bus released",
          {28'd0, frameOe, adOe, cbeOe, irdyOe}, 32'd0);
    check(!rdValid, req, "rdValid", {31'd0, rdValid}, 32'd0);
    check(reqReady, req, "reqReady", {31'd0, reqReady}, 32'd1);
  endtask

  task automatic runBurst(input logic [31:0] a, input logic [3:0] len,
                          input logic [3:0] be, input logic [15:0] tp,
                          input logic [15:0] sp);
    int effLen;
    int busBeats;
    int consIdx;
    int dataCyc;
    int cyc;
    int postCnt;
    bit inData;
    bit busDone;
    effLen = (len == 0) ? 1 : int'(len);
    busBeats = 0; consIdx = 0; dataCyc = 0; cyc = 0; postCnt = 0;
    inData = 0; busDone = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqLen = len; reqBe = be; rdReady = 1'b1;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    // R2 address phase
    check(adOe && adOut == a, "R2", "address on AD", adOut, a);
    check(cbeOe && cbeOut == 4'b0110, "R2", "read command", {28'd0, cbeOut}, 32'h6);
    check(frameOe && !frameVal && irdyOe && irdyVal, "R2", "frame low irdy high",
          {30'd0, frameVal, irdyVal}, 32'h1);
    inData = 1;
    for (int g = 0; g < 400; g++) begin
      @(negedge clk);
      cyc++;
      rdReady = !sp[cyc % 16];
      if (inData) begin
        trdyN = tp[dataCyc % 16];
        devselN = 1'b0;
        adIn = wordOf(a, busBeats);
      end else begin
        trdyN = 1'b1;
        devselN = 1'b1;
        adIn = 32'hDEAD_BEEF;
      end
      #1;
      if (inData) begin
        check(!adOe && cbeOe && cbeOut == ~be, "R3", "byte enables",
              {27'd0, adOe, cbeOut}, {28'd0, ~be});
        check(frameOe && (frameVal == (busBeats == effLen - 1)), "R6", "frame level",
              {31'd0, frameVal}, {31'd0, (busBeats == effLen - 1)});
        if (irdyVal)
          check(rdValid && !rdReady, "R5", "wait without stall",
                {30'd0, rdValid, rdReady}, 32'h2);
      end else if (busDone) begin
        postCnt++;
        if (postCnt == 1)
          check(irdyOe && irdyVal && !frameOe && !adOe && !cbeOe, "R7",
                "irdy high, rest released",
                {27'd0, irdyOe, irdyVal, frameOe, adOe, cbeOe}, 32'h18);
        else if (postCnt == 2)
          check(!irdyOe && !frameOe && !reqReady, "R8", "idle gap",
                {29'd0, irdyOe, frameOe, reqReady}, 32'd0);
        else if (postCnt == 3)
          check(reqReady, "R8", "ready after gap", {31'd0, reqReady}, 32'd1);
      end
      if (rdValid && rdReady) begin
        check(rdData == wordOf(a, consIdx), "R4", "word order", rdData, wordOf(a, consIdx));
        check(rdLast == (consIdx == effLen - 1), "R4", "last flag",
              {31'd0, rdLast}, {31'd0, (consIdx == effLen - 1)});
        consIdx++;
      end else if (rdValid) begin
        // R10: value must survive the stall; verified on the later accept
      end
      if (inData) begin
        dataCyc++;
        if (irdyOe && !irdyVal && !trdyN) begin
          busBeats++;
          if (busBeats == effLen) begin
            inData = 0;
            busDone = 1;
          end
        end
      end
      if (busDone && postCnt >= 3 && consIdx >= effLen) break;
    end
    check(consIdx == effLen, "R4", "word count", consIdx, effLen);
    trdyN = 1'b1; devselN = 1'b1; rdReady = 1'b1;
  endtask

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt == 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=done", cycleCnt);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 reset state
    checkReleased("R1");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checkReleased("R1");

    for (int i = 0; i < 5; i++) begin
      runBurst(VEC[i][71:40], VEC[i][39:36], VEC[i][35:32], VEC[i][31:16], VEC[i][15:0]);
    end

    // R9 zero length runs as one word
    runBurst(32'h5555_0000, 4'd0, 4'h7, 16'h0001, 16'h0000);

    // R10 stall: captured word must stay stable while rdReady low
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h6000_0000; reqLen = 4'd2; reqBe = 4'hF; rdReady = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    devselN = 1'b0; trdyN = 1'b0; adIn = 32'hCAFE_0001;
    @(negedge clk);
    adIn = 32'hCAFE_0002;
    repeat (3) @(negedge clk);
    #1;
    check(rdValid && rdData == 32'hCAFE_0001 && !rdLast, "R10", "held word",
          rdData, 32'hCAFE_0001);
    check(irdyOe && irdyVal, "R5", "wait during stall", {31'd0, irdyVal}, 32'd1);

    // R1 reset in mid-burst releases at once
    rstN = 1'b0;
    #1;
    checkReleased("R1");
    @(negedge clk);
    devselN = 1'b1; trdyN = 1'b1; rdReady = 1'b1;
    rstN = 1'b1;
    runBurst(32'h7000_0010, 4'd4, 4'h9, 16'h0002, 16'h0004);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule